// File: doc/BRIEF.md
# PLL Coast Window Generator

This block drives a coast signal that tells a downstream pixel-clock PLL to stop tracking horizontal sync across the vertical interval. During that interval equalization and serration pulses make horizontal sync unreliable. The window opens a programmable number of lines before vertical sync begins, stays open for all of vertical sync, and closes a programmable number of lines after vertical sync ends.

Coast has to open before vertical sync arrives, so the block measures the line count of each frame and uses it to predict the start of the next one. Horizontal sync rising edges are counted from one vertical sync rising edge to the next. The count is latched as the frame length, and the pre-coast window opens when the running count reaches that length less the pre-coast amount. Both sync inputs are active high. They pass through a two-flop stage before edge detection, and coast follows that delayed vertical sync level.

Top module: `coast_window_gen`

## Requirements
- R1: While `rst_ni` is low, `coast_o` is 0. After reset the measured frame length is forgotten and no pre-coast or post-coast window is pending.
- R2: When `vsync_i` is high at a clock edge, `coast_o` is high two clock edges later, and it stays high for as long as vertical sync stays high.
- R3: Lines are counted on rising edges of `hsync_i`. A horizontal rising edge in the same cycle as a vertical rising edge counts as line 1 of the new frame. The frame length is the count held when the next vertical rising edge arrives.
- R4: Using the last measured length L and the pre-coast amount P, coast rises at the horizontal rising edge that starts line L-P+1 of the frame (lines numbered from 1). It then stays high until vertical sync takes over.
- R5: Pre-coast is never applied until two vertical rising edges have been seen since reset, so that one complete frame has been measured.
- R6: When P is 0 or P is not less than L, no pre-coast window is opened.
- R7: At a vertical falling edge with post-coast amount Q > 0, coast stays high. It drops at the Q-th horizontal rising edge after that falling edge, and a horizontal rising edge in the same cycle as the falling edge is not counted.
- R8: With Q equal to 0, coast falls in the same cycle as the delayed vertical sync level, unless a pre-coast window is open.
- R9: A vertical rising edge during an open post-coast window ends that window. Once vertical sync falls again, coast follows only the new settings.
- R10: When the horizontal edge that closes post-coast is also the edge that opens pre-coast, `coast_o` stays high with no low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| pre_lines_i | input | 8 | Lines of coast before vertical sync |
| post_lines_i | input | 8 | Lines of coast after vertical sync |
| coast_o | output | 1 | Coast request to the PLL |

## Verification
Two events can fall on the same horizontal sync edge: the end of the post-coast window and the start of the pre-coast window. This happens in a short frame where the post amount ends exactly on the line where the predicted pre-coast begins. The bench builds that frame from the measured length of the previous frame and chooses settings that place both events on the same line. During that line it samples `coast_o` on every clock, not once per line, and a single low cycle counts as a failure.

// File: rtl/coast_pkg.sv
package coast_pkg;
  localparam int unsigned DEF_LINE_W = 12;
  localparam int unsigned DEF_AMT_W  = 8;

  typedef struct packed {
    logic rise;
    logic fall;
    logic held;  // delayed level aligned with rise/fall actions
  } sync_ev_t;
endpackage

// File: rtl/coast_edge_sync.sv
module coast_edge_sync
  import coast_pkg::*;
#(
  parameter int unsigned N = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         sig_i,
  output sync_ev_t [N-1:0]     ev_o
);
  logic [N-1:0] q1, q2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q1 <= '0;
      q2 <= '0;
    end else begin
      q1 <= sig_i;
      q2 <= q1;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_ev
    assign ev_o[g].rise = q1[g] & ~q2[g];
    assign ev_o[g].fall = ~q1[g] & q2[g];
    assign ev_o[g].held = q2[g];
  end
endmodule

// File: rtl/coast_line_tracker.sv
module coast_line_tracker #(
  parameter int unsigned LINE_W = 12,
  parameter int unsigned AMT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_rise_i,
  input  logic              vs_rise_i,
  input  logic [AMT_W-1:0]  pre_lines_i,
  output logic [LINE_W-1:0] line_cnt_o,
  output logic [LINE_W-1:0] frame_len_o,
  output logic              frame_valid_o,
  output logic              pre_active_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic              seen_vs;
  logic [LINE_W-1:0] line_inc;
  logic [LINE_W-1:0] pre_ext;
  logic [LINE_W-1:0] pre_start;
  logic              pre_ok;

  assign line_inc  = (line_cnt_o == LINE_MAX) ? line_cnt_o : line_cnt_o + 1'b1;
  assign pre_ext   = LINE_W'(pre_lines_i);
  assign pre_start = frame_len_o - pre_ext + 1'b1;
  assign pre_ok    = frame_valid_o && (pre_ext != '0) && (pre_ext < frame_len_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_cnt_o    <= '0;
      frame_len_o   <= '0;
      frame_valid_o <= 1'b0;
      seen_vs       <= 1'b0;
    end else if (vs_rise_i) begin
      frame_len_o <= line_cnt_o;
      line_cnt_o  <= hs_rise_i ? LINE_W'(1) : '0;
      seen_vs     <= 1'b1;
      if (seen_vs) frame_valid_o <= 1'b1;
    end else if (hs_rise_i) begin
      line_cnt_o <= line_inc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        pre_active_o <= 1'b0;
    else if (vs_rise_i)                                 pre_active_o <= 1'b0;
    else if (hs_rise_i && pre_ok && line_inc == pre_start) pre_active_o <= 1'b1;
  end
endmodule

// File: rtl/coast_post_timer.sv
module coast_post_timer #(
  parameter int unsigned AMT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_rise_i,
  input  logic             vs_rise_i,
  input  logic             vs_fall_i,
  input  logic [AMT_W-1:0] post_lines_i,
  output logic             post_active_o
);
  logic [AMT_W-1:0] remain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      post_active_o <= 1'b0;
      remain        <= '0;
    end else if (vs_rise_i) begin
      post_active_o <= 1'b0;
      remain        <= '0;
    end else if (vs_fall_i) begin
      post_active_o <= (post_lines_i != '0);
      remain        <= post_lines_i;
    end else if (post_active_o && hs_rise_i) begin
      remain <= remain - 1'b1;
      if (remain == AMT_W'(1)) post_active_o <= 1'b0;
    end
  end
endmodule

// File: rtl/coast_window_gen.sv
module coast_window_gen
  import coast_pkg::*;
#(
  parameter int unsigned LINE_W = DEF_LINE_W,
  parameter int unsigned AMT_W  = DEF_AMT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic [AMT_W-1:0] pre_lines_i,
  input  logic [AMT_W-1:0] post_lines_i,
  output logic             coast_o
);
  localparam int unsigned HS = 0;
  localparam int unsigned VS = 1;

  sync_ev_t [1:0]    ev;
  logic              hs_rise, vs_rise, vs_fall, vs_held;
  logic [LINE_W-1:0] line_cnt, frame_len;
  logic              frame_valid, pre_active, post_active;

  coast_edge_sync #(.N(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({vsync_i, hsync_i}),
    .ev_o   (ev)
  );

  assign hs_rise = ev[HS].rise;
  assign vs_rise = ev[VS].rise;
  assign vs_fall = ev[VS].fall;
  assign vs_held = ev[VS].held;

  coast_line_tracker #(.LINE_W(LINE_W), .AMT_W(AMT_W)) u_track (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hs_rise_i     (hs_rise),
    .vs_rise_i     (vs_rise),
    .pre_lines_i   (pre_lines_i),
    .line_cnt_o    (line_cnt),
    .frame_len_o   (frame_len),
    .frame_valid_o (frame_valid),
    .pre_active_o  (pre_active)
  );

  coast_post_timer #(.AMT_W(AMT_W)) u_post (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hs_rise_i     (hs_rise),
    .vs_rise_i     (vs_rise),
    .vs_fall_i     (vs_fall),
    .post_lines_i  (post_lines_i),
    .post_active_o (post_active)
  );

  assign coast_o = pre_active | vs_held | post_active;
endmodule

// File: rtl/coast_window_chk.sv
module coast_window_chk #(
  parameter int unsigned LINE_W = 12,
  parameter int unsigned AMT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vsync_i,
  input logic [AMT_W-1:0]  pre_lines_i,
  input logic [AMT_W-1:0]  post_lines_i,
  input logic              coast_o,
  input logic              hs_rise,
  input logic              vs_rise,
  input logic              vs_fall,
  input logic [LINE_W-1:0] line_cnt,
  input logic [LINE_W-1:0] frame_len,
  input logic              frame_valid,
  input logic              pre_active,
  input logic              post_active
);
  assert_vsync_covers_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 2) && $past(vsync_i, 2)) |-> coast_o);

  assert_line_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_rise |=> (line_cnt <= LINE_W'(1)));

  assert_pre_needs_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_active |-> frame_valid);

  assert_pre_bounds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pre_active) |-> $past(pre_lines_i != '0 && LINE_W'(pre_lines_i) < frame_len));

  assert_post_ends_on_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(post_active) |-> $past(hs_rise || vs_rise));

  assert_post_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_fall && post_lines_i == '0) |=> !post_active);

  assert_vs_clears_post_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_rise |=> !post_active);
endmodule

bind coast_window_gen coast_window_chk #(.LINE_W(LINE_W), .AMT_W(AMT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .vsync_i      (vsync_i),
  .pre_lines_i  (pre_lines_i),
  .post_lines_i (post_lines_i),
  .coast_o      (coast_o),
  .hs_rise      (hs_rise),
  .vs_rise      (vs_rise),
  .vs_fall      (vs_fall),
  .line_cnt     (line_cnt),
  .frame_len    (frame_len),
  .frame_valid  (frame_valid),
  .pre_active   (pre_active),
  .post_active  (post_active)
);

// File: tb/tb_coast_window_gen.sv
module tb_coast_window_gen;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hsync_i = 1'b0;
  logic       vsync_i = 1'b0;
  logic [7:0] pre_lines_i = '0;
  logic [7:0] post_lines_i = '0;
  logic       coast_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  coast_window_gen dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .hsync_i      (hsync_i),
    .vsync_i      (vsync_i),
    .pre_lines_i  (pre_lines_i),
    .post_lines_i (post_lines_i),
    .coast_o      (coast_o)
  );

  // frame vectors: {lines, vsync lines, pre, post}
  localparam int NVEC = 10;
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd20, 8'd3, 8'd0,   8'd0},
    {8'd20, 8'd3, 8'd4,   8'd2},
    {8'd20, 8'd2, 8'd0,   8'd5},
    {8'd16, 8'd3, 8'd6,   8'd1},
    {8'd16, 8'd3, 8'd16,  8'd0},
    {8'd16, 8'd2, 8'd15,  8'd0},
    {8'd18, 8'd2, 8'd3,   8'd4},
    {8'd18, 8'd2, 8'd10,  8'd6},
    {8'd12, 8'd4, 8'd255, 8'd255},
    {8'd12, 8'd1, 8'd0,   8'd0}
  };

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: coast=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // one line of 8 clocks; smp taken at cycle 6, all_hi is AND over all cycles
  task automatic run_line(input bit vs_on, input bit vs_off, output logic smp, output logic all_hi);
    all_hi = 1'b1;
    smp = 1'b0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (c == 0) begin
        hsync_i = 1'b1;
        if (vs_on) vsync_i = 1'b1;
      end
      if (c == 2) hsync_i = 1'b0;
      if (c == 3 && vs_off) vsync_i = 1'b0;
      if (c == 6) smp = coast_o;
      all_hi = all_hi & coast_o;
    end
  endtask

  function automatic logic expect_coast(input int l, input int v, input int post, input int pre,
                                        input int tprev, input bit have_prev);
    return (l < v + post) || (have_prev && pre != 0 && pre < tprev && l >= tprev - pre);
  endfunction

  function automatic string req_of(input int f, input int l, input int v, input int post,
                                   input int pre, input int tprev);
    if (f == 9 && l == 1) return "R9";
    if (f == 7)           return "R10";
    if (l < v)            return "R2";
    if (l < v + post)     return "R7";
    if (f == 3)           return "R3";
    if (f == 4)           return "R6";
    if (pre != 0 && pre < tprev && l >= tprev - pre) return "R4";
    if (post == 0)        return "R8";
    return "R6";
  endfunction

  task automatic run_frame(input int f, input int t, input int v, input int pre, input int post,
                           input int tprev, input bit have_prev, input string force_req);
    logic smp, all_hi;
    pre_lines_i  = 8'(pre);
    post_lines_i = 8'(post);
    for (int l = 0; l < t; l++) begin
      run_line(l == 0, l == v, smp, all_hi);
      check(force_req != "" ? force_req : req_of(f, l, v, post, pre, tprev), smp,
            expect_coast(l, v, post, pre, tprev, have_prev),
            $sformatf("frame %0d line %0d", f, l));
      // R10: post closes and pre opens on the same edge -> no low cycle in that line
      if (f == 7 && l == tprev - pre)
        check("R10", all_hi, 1'b1, $sformatf("frame %0d handoff line %0d every cycle", f, l));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: timeout actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int tprev;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", coast_o, 1'b0, "during reset");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", coast_o, 1'b0, "after reset idle");

    tprev = 0;
    for (int i = 0; i < NVEC; i++) begin
      run_frame(i, int'(VEC[i][31:24]), int'(VEC[i][23:16]), int'(VEC[i][15:8]),
                int'(VEC[i][7:0]), tprev, i > 0, "");
      tprev = int'(VEC[i][31:24]);
    end

    // R1: asynchronous reset with vsync high mid-frame
    @(negedge clk);
    vsync_i = 1'b1;
    hsync_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1", coast_o, 1'b0, "reset asserted with vsync high");
    vsync_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", coast_o, 1'b0, "after mid-run reset");

    // R5: first frame after reset has no prediction
    run_frame(100, 10, 2, 3, 0, 0, 1'b0, "R5");
    // R4: second frame uses the measured length
    run_frame(101, 10, 2, 3, 0, 10, 1'b1, "R4");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule